// File: doc/BRIEF.md
# Periodic Tick Timer

This block produces a steady interrupt tick from the oscillator clock. A binary prescaler divides the clock by a selectable power of two. A modulus counter then divides that tick again by a value from 1 to 16. A 7-bit control word, written over a simple register strobe, selects both dividers. When a full period has elapsed, a sticky tick flag is set. The next period starts on the following cycle, so no cycle is lost between periods. Software clears the flag by writing a 1 to it.

Whenever the flag is set and the interrupt enable input is high, the interrupt output is asserted. A control write always restarts the current period, so software can rewrite the control word at regular intervals and use the timer as a watchdog. Two configuration inputs set what happens in the low-power modes. In wait mode the timer either keeps counting, or it stops and clears its dividers. In pseudo-stop mode it either keeps counting, or it freezes and keeps its count. The base exponent of the prescaler is the parameter `PRE_BASE`, which is 10 by default.

Top module: `rtick_timer`

## Requirements
- R1: After reset the control word is 0, the dividers are cleared, and `tick_flag` and `irq` are both 0.
- R2: When the prescale field (control bits 6:4) is 0, the timer is off and the flag never sets, whatever the modulus field holds.
- R3: With prescale code S (1..7) and modulus field M (control bits 3:0), the period is (M+1)·2^(PRE_BASE-1+S) clock cycles. After a control write, the flag is first visible that many cycles after the write edge.
- R4: Periods follow each other with no dead cycles. The next flag set comes exactly one period after the previous one.
- R5: Any control write restarts the current period from zero, even when the value written is unchanged.
- R6: A clear strobe with the clear bit at 1 clears the flag. A clear strobe with the clear bit at 0 leaves the flag unchanged.
- R7: If a clear and a new timeout fall on the same cycle, the flag stays set.
- R8: `irq` is high exactly when the flag is set and `irq_en` is 1.
- R9: With `wait_halt_cfg`=1, wait mode stops the timer and clears both dividers. After wait mode ends, a full period is needed before the next flag.
- R10: With `wait_halt_cfg`=0, the timer counts through wait mode without any change.
- R11: With `stop_run_cfg`=0, pseudo-stop mode freezes the dividers with their count kept. Counting resumes from that count when the mode ends.
- R12: With `stop_run_cfg`=1, the timer counts through pseudo-stop mode without any change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 7 | Control word: prescale code in bits 6:4, modulus in bits 3:0 |
| clr_wr | input | 1 | Flag clear write strobe |
| clr_bit | input | 1 | Data bit of the clear write; 1 clears the flag |
| irq_en | input | 1 | Interrupt enable |
| wait_mode | input | 1 | Wait mode indication |
| stop_mode | input | 1 | Pseudo-stop mode indication |
| wait_halt_cfg | input | 1 | 1: stop and clear the timer in wait mode |
| stop_run_cfg | input | 1 | 1: keep the timer counting in pseudo-stop mode |
| tick_flag | output | 1 | Sticky timeout flag |
| irq | output | 1 | Interrupt request |

## Verification
The period is measured with several pairings of prescale code and modulus, including the shortest, a unit modulus and the longest. These tell apart errors in the power-of-two tap, in the M+1 multiplier and in the counter width. The intervals between successive flags show whether any dead cycle appears at the wrap. Restarts in mid-period, and clears that fall on the same edge as a timeout, check the restart behaviour and the set-over-clear priority. Each low-power mode is run with both settings of its configuration input. A frozen count resumes where it stopped, while a cleared count needs a full period again; the measured delays tell these two behaviours apart.

// File: rtl/rtick_pkg.sv
`timescale 1ns/1ps
package rtick_pkg;

    localparam int CTL_PRE_W = 3;
    localparam int CTL_MOD_W = 4;
    localparam int CTL_W     = CTL_PRE_W + CTL_MOD_W;

    typedef struct packed {
        logic [CTL_PRE_W-1:0] pre_sel;
        logic [CTL_MOD_W-1:0] mod_sel;
    } rtick_ctl_t;

    typedef enum logic [1:0] {
        RUN_COUNT = 2'd0,
        RUN_HOLD  = 2'd1,
        RUN_CLEAR = 2'd2
    } rtick_run_e;

    // Last prescaler count for a selection code: 2^(base-1+sel) - 1.
    function automatic longint unsigned pre_last_f(int base, logic [CTL_PRE_W-1:0] sel);
        longint unsigned one;
        one = 64'd1;
        return (one << (base - 1 + int'(sel))) - 64'd1;
    endfunction

endpackage

// File: rtl/rtick_ctrl.sv
`timescale 1ns/1ps
module rtick_ctrl
    import rtick_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                ctl_wr,
    input  logic [CTL_W-1:0]    ctl_wdata,
    input  logic                wait_mode,
    input  logic                stop_mode,
    input  logic                wait_halt_cfg,
    input  logic                stop_run_cfg,
    output rtick_ctl_t          ctl_q,
    output rtick_run_e          run
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else if (ctl_wr) begin
            ctl_q <= rtick_ctl_t'(ctl_wdata);
        end
    end

    always_comb begin
        if (ctl_wr) begin
            run = RUN_CLEAR;
        end else if (ctl_q.pre_sel == '0) begin
            run = RUN_CLEAR;
        end else if (wait_mode && wait_halt_cfg) begin
            run = RUN_CLEAR;
        end else if (stop_mode && !stop_run_cfg) begin
            run = RUN_HOLD;
        end else begin
            run = RUN_COUNT;
        end
    end

endmodule

// File: rtl/rtick_divider.sv
`timescale 1ns/1ps
module rtick_divider
    import rtick_pkg::*;
#(
    parameter int PRE_BASE = 10,
    localparam int PCNT_W  = PRE_BASE + (1 << CTL_PRE_W) - 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  rtick_ctl_t            ctl_q,
    input  rtick_run_e            run,
    output logic [PCNT_W-1:0]     pre_cnt,
    output logic [CTL_MOD_W-1:0]  mod_cnt,
    output logic                  tmo
);

    logic [PCNT_W-1:0] pre_last;
    logic              pre_wrap;

    assign pre_last = PCNT_W'(pre_last_f(PRE_BASE, ctl_q.pre_sel));
    assign pre_wrap = (pre_cnt == pre_last);
    assign tmo      = (run == RUN_COUNT) && pre_wrap && (mod_cnt == ctl_q.mod_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_cnt <= '0;
            mod_cnt <= '0;
        end else begin
            unique case (run)
                RUN_CLEAR: begin
                    pre_cnt <= '0;
                    mod_cnt <= '0;
                end
                RUN_COUNT: begin
                    if (pre_wrap) begin
                        pre_cnt <= '0;
                        mod_cnt <= (mod_cnt == ctl_q.mod_sel) ? '0 : mod_cnt + 1'b1;
                    end else begin
                        pre_cnt <= pre_cnt + 1'b1;
                    end
                end
                default: begin
                    pre_cnt <= pre_cnt;
                    mod_cnt <= mod_cnt;
                end
            endcase
        end
    end

endmodule

// File: rtl/rtick_flag.sv
`timescale 1ns/1ps
module rtick_flag (
    input  logic clk,
    input  logic rst,
    input  logic tmo,
    input  logic clr_wr,
    input  logic clr_bit,
    output logic flag
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (tmo) begin
            flag <= 1'b1;
        end else if (clr_wr && clr_bit) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/rtick_timer.sv
`timescale 1ns/1ps
module rtick_timer
    import rtick_pkg::*;
#(
    parameter int PRE_BASE = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             clr_wr,
    input  logic             clr_bit,
    input  logic             irq_en,
    input  logic             wait_mode,
    input  logic             stop_mode,
    input  logic             wait_halt_cfg,
    input  logic             stop_run_cfg,
    output logic             tick_flag,
    output logic             irq
);

    localparam int PCNT_W = PRE_BASE + (1 << CTL_PRE_W) - 2;

    rtick_ctl_t            ctl_q;
    rtick_run_e            run;
    logic [PCNT_W-1:0]     pre_cnt;
    logic [CTL_MOD_W-1:0]  mod_cnt;
    logic                  tmo;

    rtick_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .ctl_wr        (ctl_wr),
        .ctl_wdata     (ctl_wdata),
        .wait_mode     (wait_mode),
        .stop_mode     (stop_mode),
        .wait_halt_cfg (wait_halt_cfg),
        .stop_run_cfg  (stop_run_cfg),
        .ctl_q         (ctl_q),
        .run           (run)
    );

    rtick_divider #(.PRE_BASE(PRE_BASE)) u_div (
        .clk     (clk),
        .rst     (rst),
        .ctl_q   (ctl_q),
        .run     (run),
        .pre_cnt (pre_cnt),
        .mod_cnt (mod_cnt),
        .tmo     (tmo)
    );

    rtick_flag u_flag (
        .clk     (clk),
        .rst     (rst),
        .tmo     (tmo),
        .clr_wr  (clr_wr),
        .clr_bit (clr_bit),
        .flag    (tick_flag)
    );

    assign irq = tick_flag & irq_en;

endmodule

// File: rtl/rtick_checker.sv
`timescale 1ns/1ps
module rtick_checker #(
    parameter int PCNT_W = 16,
    parameter int MOD_W  = 4,
    parameter int PRE_W  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              ctl_wr,
    input logic              clr_wr,
    input logic              clr_bit,
    input logic              irq_en,
    input logic              wait_mode,
    input logic              stop_mode,
    input logic              wait_halt_cfg,
    input logic              stop_run_cfg,
    input logic [PRE_W-1:0]  pre_sel,
    input logic [PCNT_W-1:0] pre_cnt,
    input logic [MOD_W-1:0]  mod_cnt,
    input logic              tmo,
    input logic              tick_flag,
    input logic              irq
);

    // R1: the flag is clear on the first cycle after reset
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !tick_flag);

    // R2: the flag can only rise while a nonzero prescale code is held
    a_r2_off_no_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(tick_flag) |-> ($past(pre_sel) != '0));

    // R5: a control write leaves both dividers at zero
    a_r5_restart: assert property (@(posedge clk) disable iff (rst)
        ctl_wr |=> (pre_cnt == '0) && (mod_cnt == '0));

    // R6: a clear with bit 1 and no timeout drops the flag
    a_r6_clear: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && clr_bit && !tmo) |=> !tick_flag);

    // R7: a timeout always leaves the flag set, even with a clear beside it
    a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
        tmo |=> tick_flag);

    // R8: no request without enable, no request without flag
    a_r8_irq_gate: assert property (@(posedge clk) disable iff (rst)
        irq |-> (irq_en && tick_flag));

    // R9: wait mode with the halt setting leaves the dividers cleared
    a_r9_wait_clear: assert property (@(posedge clk) disable iff (rst)
        (wait_mode && wait_halt_cfg) |=> (pre_cnt == '0) && (mod_cnt == '0));

    // R11: pseudo-stop without the run setting keeps the count
    a_r11_stop_hold: assert property (@(posedge clk) disable iff (rst)
        (stop_mode && !stop_run_cfg && !ctl_wr && !(wait_mode && wait_halt_cfg))
        |=> $stable(pre_cnt) && $stable(mod_cnt));

endmodule

bind rtick_timer rtick_checker #(
    .PCNT_W (PCNT_W),
    .MOD_W  (rtick_pkg::CTL_MOD_W),
    .PRE_W  (rtick_pkg::CTL_PRE_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .ctl_wr        (ctl_wr),
    .clr_wr        (clr_wr),
    .clr_bit       (clr_bit),
    .irq_en        (irq_en),
    .wait_mode     (wait_mode),
    .stop_mode     (stop_mode),
    .wait_halt_cfg (wait_halt_cfg),
    .stop_run_cfg  (stop_run_cfg),
    .pre_sel       (ctl_q.pre_sel),
    .pre_cnt       (pre_cnt),
    .mod_cnt       (mod_cnt),
    .tmo           (tmo),
    .tick_flag     (tick_flag),
    .irq           (irq)
);

// File: tb/rtick_timer_test.sv
`timescale 1ns/1ps
module rtick_timer_test;

    localparam int B = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctl_wr = 1'b0;
    logic [6:0] ctl_wdata = '0;
    logic       clr_wr = 1'b0;
    logic       clr_bit = 1'b0;
    logic       irq_en = 1'b0;
    logic       wait_mode = 1'b0;
    logic       stop_mode = 1'b0;
    logic       wait_halt_cfg = 1'b0;
    logic       stop_run_cfg = 1'b0;
    logic       tick_flag;
    logic       irq;

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    string phase = "R1";

    always #2 clk = ~clk;

    rtick_timer #(.PRE_BASE(B)) uut (
        .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .clr_wr(clr_wr), .clr_bit(clr_bit), .irq_en(irq_en),
        .wait_mode(wait_mode), .stop_mode(stop_mode),
        .wait_halt_cfg(wait_halt_cfg), .stop_run_cfg(stop_run_cfg),
        .tick_flag(tick_flag), .irq(irq)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural reference: elapsed cycles against the period length.
    int m_code = 0;
    int m_mod = 0;
    int m_elapsed = 0;
    bit m_flag = 1'b0;

    function automatic int period(input int code, input int m);
        return (m + 1) * (1 << (B - 1 + code));
    endfunction

    always @(posedge clk) begin
        bit t;
        t = 1'b0;
        if (rst) begin
            m_code = 0; m_mod = 0; m_elapsed = 0; m_flag = 1'b0;
        end else begin
            if (ctl_wr) begin
                m_elapsed = 0;
                m_code = int'(ctl_wdata[6:4]);
                m_mod  = int'(ctl_wdata[3:0]);
            end else if (m_code == 0) begin
                m_elapsed = 0;
            end else if (wait_mode && wait_halt_cfg) begin
                m_elapsed = 0;
            end else if (stop_mode && !stop_run_cfg) begin
                m_elapsed = m_elapsed;
            end else begin
                m_elapsed++;
                if (m_elapsed == period(m_code, m_mod)) begin
                    t = 1'b1;
                    m_elapsed = 0;
                end
            end
            if (t) m_flag = 1'b1;
            else if (clr_wr && clr_bit) m_flag = 1'b0;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            chk(tick_flag == m_flag, {phase, " model flag"}, int'(tick_flag), int'(m_flag));
            chk(irq == (m_flag && irq_en), {phase, " model irq"}, int'(irq), int'(m_flag && irq_en));
        end
    end

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog expired in phase %s", phase);
            finish_run();
        end
    end

    // Restart with a new control word and clear the flag on the same edge.
    task automatic restart(input int code, input int m);
        ctl_wr = 1'b1;
        ctl_wdata = {code[2:0], m[3:0]};
        clr_wr = 1'b1; clr_bit = 1'b1;
        @(negedge clk);
        ctl_wr = 1'b0; clr_wr = 1'b0; clr_bit = 1'b0;
    endtask

    task automatic clear_pulse(input bit b);
        clr_wr = 1'b1; clr_bit = b;
        @(negedge clk);
        clr_wr = 1'b0; clr_bit = 1'b0;
    endtask

    task automatic wait_flag(output int n);
        n = 0;
        while (!tick_flag && n < 20000) begin
            @(negedge clk);
            n++;
        end
        if (!tick_flag) n = -1;
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(tick_flag == 1'b0, "R1 flag after reset", int'(tick_flag), 0);
        chk(irq == 1'b0, "R1 irq after reset", int'(irq), 0);
        repeat (100) @(negedge clk);
        chk(tick_flag == 1'b0, "R1 control word starts off", int'(tick_flag), 0);

        phase = "R2";
        restart(0, 9);
        repeat (300) @(negedge clk);
        chk(tick_flag == 1'b0, "R2 code 0 with modulus 9", int'(tick_flag), 0);
        restart(0, 0);
        repeat (50) @(negedge clk);
        chk(tick_flag == 1'b0, "R2 code 0 with modulus 0", int'(tick_flag), 0);

        phase = "R3";
        restart(1, 2); wait_flag(n);
        chk(n == period(1, 2), "R3 code1 mod2", n, period(1, 2));
        restart(3, 0); wait_flag(n);
        chk(n == period(3, 0), "R3 code3 mod0", n, period(3, 0));
        restart(1, 0); wait_flag(n);
        chk(n == period(1, 0), "R3 shortest", n, period(1, 0));
        restart(7, 15); wait_flag(n);
        chk(n == period(7, 15), "R3 code7 mod15", n, period(7, 15));

        phase = "R4";
        restart(2, 3); wait_flag(n);
        clear_pulse(1'b1); wait_flag(n);
        chk(n == period(2, 3) - 1, "R4 back-to-back period", n + 1, period(2, 3));
        clear_pulse(1'b1); wait_flag(n);
        chk(n == period(2, 3) - 1, "R4 third period", n + 1, period(2, 3));

        phase = "R5";
        restart(2, 1);
        repeat (10) @(negedge clk);
        chk(tick_flag == 1'b0, "R5 mid-period", int'(tick_flag), 0);
        restart(2, 1); wait_flag(n);
        chk(n == period(2, 1), "R5 same-value rewrite restarts", n, period(2, 1));

        phase = "R6";
        clear_pulse(1'b0);
        chk(tick_flag == 1'b1, "R6 clear with bit 0 ignored", int'(tick_flag), 1);
        clear_pulse(1'b1);
        chk(tick_flag == 1'b0, "R6 clear with bit 1", int'(tick_flag), 0);

        phase = "R7";
        restart(2, 0); wait_flag(n);
        clear_pulse(1'b1);
        repeat (period(2, 0) - 2) @(negedge clk);
        clear_pulse(1'b1);
        chk(tick_flag == 1'b1, "R7 set wins over clear", int'(tick_flag), 1);

        phase = "R8";
        irq_en = 1'b0; @(negedge clk);
        chk(irq == 1'b0, "R8 flag set, enable 0", int'(irq), 0);
        irq_en = 1'b1; @(negedge clk);
        chk(irq == 1'b1, "R8 flag set, enable 1", int'(irq), 1);
        clear_pulse(1'b1);
        chk(irq == 1'b0, "R8 flag clear, enable 1", int'(irq), 0);

        phase = "R9";
        wait_halt_cfg = 1'b1;
        restart(2, 1);
        repeat (8) @(negedge clk);
        wait_mode = 1'b1;
        repeat (30) @(negedge clk);
        chk(tick_flag == 1'b0, "R9 halted in wait", int'(tick_flag), 0);
        wait_mode = 1'b0;
        wait_flag(n);
        chk(n == period(2, 1), "R9 full period after wait", n, period(2, 1));

        phase = "R10";
        wait_halt_cfg = 1'b0;
        restart(2, 1);
        wait_mode = 1'b1;
        wait_flag(n);
        chk(n == period(2, 1), "R10 counting through wait", n, period(2, 1));
        wait_mode = 1'b0;

        phase = "R11";
        stop_run_cfg = 1'b0;
        restart(2, 1);
        n = 0;
        while (!tick_flag && n < 1000) begin
            if (n == 4) stop_mode = 1'b1;
            if (n == 24) stop_mode = 1'b0;
            @(negedge clk);
            n++;
        end
        chk(n == period(2, 1) + 20, "R11 frozen count resumes", n, period(2, 1) + 20);

        phase = "R12";
        stop_run_cfg = 1'b1;
        restart(2, 1);
        stop_mode = 1'b1;
        wait_flag(n);
        chk(n == period(2, 1), "R12 counting through pseudo-stop", n, period(2, 1));
        stop_mode = 1'b0;

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule